// File: doc/BRIEF.md
# Center-Aligned Three-Phase Inverter PWM

This block drives the six switches of a three-phase inverter bridge. A single up/down counter sweeps from zero to a programmed period value and back, so one switching cycle lasts twice the period in clocks. Each phase compares the counter against its own compare value. The result is split into a high-side and a low-side gate. Each gate turns on only after a programmable guard interval and turns off at once, so the two switches of a leg never conduct together. At 72 MHz a 20 kHz carrier needs a period value of 1800, and guard intervals of roughly 50 ns to 400 ns need about 4 to 29 clocks.

A one-clock converter trigger is raised at the top of every count, where the low-side switches sit midway through their on-window and no edge is near. Compare values and the period are held in shadow copies that reload only when the counter is at zero, so a pulse is never cut short part way. A small write port sets the period, the guard interval and a run bit. A synchronous kill input forces every gate low while the counter keeps running.

Top module: `pwm3_bridge`

## Requirements
- R1: After reset all six gates and the trigger are low, the run bit is 0, the period register holds PERIOD_RST and the guard register holds DEAD_RST.
- R2: The high-side and low-side gate of the same phase are never high in the same cycle.
- R3: With run on, period P and guard d, a phase with compare c where 0 < c < P has its high side on max(0, 2c-1-d) cycles and its low side on max(0, 2P-2c+1-d) cycles in every 2P-cycle window.
- R4: A gate rises only after both gates of its phase have been low for at least d consecutive cycles.
- R5: A compare of 0 keeps the high side off and the low side on for all 2P cycles. A compare of P or more keeps the high side on and the low side off for all 2P cycles. Neither case produces any pulse.
- R6: adc_trig is a single-cycle pulse, once per 2P cycles. It rises P-c-d cycles after the rise of a low-side gate whose phase has compare c, whenever c+d < P.
- R7: A compare value takes effect only when the counter reaches zero. After a compare change made at a trigger, the low side of that phase still falls P-c_old+1 cycles after that trigger.
- R8: While pwm_off is high, all six gates are low from the next cycle. After pwm_off falls, every gate stays low for at least d further cycles.
- R9: While the run bit is 0, the counter rests at zero and all gates and the trigger are low.
- R10: A new period takes effect at the next counter zero. The trigger interval that spans the change is P_old + P_new and later intervals are 2*P_new. A written period below 2 is stored as 2.
- R11: Register writes use cfg_we with cfg_addr: 0 selects the period (full width), 1 selects the guard interval in clocks (low DT_W bits), and 2 selects the run bit (bit 0). Phase A maps to bit 0 of gate_hi and gate_lo, B to bit 1 and C to bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CNT_W | Register write data |
| cmp_a | input | CNT_W | Phase A compare value |
| cmp_b | input | CNT_W | Phase B compare value |
| cmp_c | input | CNT_W | Phase C compare value |
| pwm_off | input | 1 | Synchronous kill, forces all gates low |
| gate_hi | output | 3 | High-side gate per phase |
| gate_lo | output | 3 | Low-side gate per phase |
| adc_trig | output | 1 | Single-cycle converter trigger at the counter apex |

## Verification
If the counter direction or the period shadow is wrong, the trigger spacing and the per-window on-counts change in the first full carrier cycle after the next zero. A guard counter that is stale or fails to saturate either lets the two gates of a leg overlap, which is visible in the same cycle, or shifts each on-time by the error. A compare shadow that loads too early moves the low-side fall that follows the trigger, and this is visible within half a carrier cycle. A broken kill path shows on the gates one clock after pwm_off rises.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

   typedef enum logic {
      DIR_UP = 1'b0,
      DIR_DN = 1'b1
   } cnt_dir_e;

   typedef enum logic [1:0] {
      SEL_PERIOD = 2'd0,
      SEL_GUARD  = 2'd1,
      SEL_RUN    = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

endpackage

// File: rtl/pwm3_cfg.sv
module pwm3_cfg
   import pwm3_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int DT_W       = 5,
   parameter int PERIOD_RST = 1800,
   parameter int DEAD_RST   = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] period_q,
   output logic [DT_W-1:0]  dead_q,
   output logic             en_q
);

   localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(2);

   cfg_sel_e sel;
   assign sel = cfg_sel_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= CNT_W'(PERIOD_RST);
         dead_q   <= DT_W'(DEAD_RST);
         en_q     <= 1'b0;
      end else if (we) begin
         unique case (sel)
            SEL_PERIOD: period_q <= (wdata < PER_MIN) ? PER_MIN : wdata;
            SEL_GUARD:  dead_q   <= wdata[DT_W-1:0];
            SEL_RUN:    en_q     <= wdata[0];
            default:    ;
         endcase
      end
   end

endmodule

// File: rtl/pwm3_updown.sv
module pwm3_updown
   import pwm3_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] period_in,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] per_act,
   output logic             load,
   output logic             apex
);

   cnt_dir_e dir_q;

   assign load = (cnt_q == '0);
   assign apex = en && (dir_q == DIR_UP) && (cnt_q == per_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         dir_q   <= DIR_UP;
         per_act <= CNT_W'(2);
      end else if (!en) begin
         cnt_q   <= '0;
         dir_q   <= DIR_UP;
         per_act <= period_in;
      end else if (load) begin
         per_act <= period_in;
         cnt_q   <= CNT_W'(1);
         dir_q   <= DIR_UP;
      end else if (dir_q == DIR_UP) begin
         if (cnt_q == per_act) begin
            dir_q <= DIR_DN;
            cnt_q <= cnt_q - 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
   parameter int DT_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw,
   input  logic            allow,
   input  logic [DT_W-1:0] dead,
   output logic            hi,
   output logic            lo
);

   localparam logic [DT_W-1:0] AGE_MAX = '1;

   logic            raw_d;
   logic [DT_W-1:0] age_q;
   logic [DT_W-1:0] age_c;
   logic            settled;

   // cycles the raw level has held, restarted by every edge
   assign age_c   = (raw != raw_d) ? '0 : age_q;
   assign settled = (age_c >= dead);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_d <= 1'b0;
         age_q <= '0;
         hi    <= 1'b0;
         lo    <= 1'b0;
      end else begin
         raw_d <= raw;
         if (!allow) begin
            age_q <= '0;
            hi    <= 1'b0;
            lo    <= 1'b0;
         end else begin
            age_q <= (age_c == AGE_MAX) ? age_c : age_c + 1'b1;
            hi    <= raw && settled;
            lo    <= !raw && settled;
         end
      end
   end

endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
   parameter int CNT_W = 12,
   parameter int DT_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             allow,
   input  logic             load,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] per_act,
   input  logic [CNT_W-1:0] cmp_in,
   input  logic [DT_W-1:0]  dead,
   output logic             hi,
   output logic             lo
);

   logic [CNT_W-1:0] cmp_act;
   logic             raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_act <= '0;
         raw_q   <= 1'b0;
      end else begin
         if (load) cmp_act <= cmp_in;
         // full-period compare pins the leg high with no notch at the apex
         raw_q <= en && ((cmp_act >= per_act) || (cnt < cmp_act));
      end
   end

   pwm3_deadband #(.DT_W(DT_W)) u_db (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_q),
      .allow (allow),
      .dead  (dead),
      .hi    (hi),
      .lo    (lo)
   );

endmodule

// File: rtl/pwm3_bridge.sv
module pwm3_bridge
   import pwm3_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int DT_W       = 5,
   parameter int PERIOD_RST = 1800,
   parameter int DEAD_RST   = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CNT_W-1:0] cfg_wdata,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_b,
   input  logic [CNT_W-1:0] cmp_c,
   input  logic             pwm_off,
   output logic [2:0]       gate_hi,
   output logic [2:0]       gate_lo,
   output logic             adc_trig
);

   localparam int NPH = 3;

   generate
      if (CNT_W < 3) begin : g_bad_cnt_w
         $error("pwm3_bridge: CNT_W must be at least 3");
      end
      if (DT_W < 1 || DT_W > CNT_W) begin : g_bad_dt_w
         $error("pwm3_bridge: DT_W must lie in 1..CNT_W");
      end
      if (PERIOD_RST < 2 || PERIOD_RST >= (1 << CNT_W)) begin : g_bad_per
         $error("pwm3_bridge: PERIOD_RST out of range");
      end
      if (DEAD_RST < 0 || DEAD_RST >= (1 << DT_W)) begin : g_bad_dead
         $error("pwm3_bridge: DEAD_RST out of range");
      end
   endgenerate

   logic [CNT_W-1:0] period_q;
   logic [DT_W-1:0]  dead_q;
   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_act;
   logic             load;
   logic             apex;
   logic             allow;
   logic             trig_p1;
   logic [CNT_W-1:0] cmp_in [NPH];

   assign cmp_in[0] = cmp_a;
   assign cmp_in[1] = cmp_b;
   assign cmp_in[2] = cmp_c;
   assign allow     = en_q && !pwm_off;

   pwm3_cfg #(
      .CNT_W(CNT_W), .DT_W(DT_W), .PERIOD_RST(PERIOD_RST), .DEAD_RST(DEAD_RST)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .period_q (period_q),
      .dead_q   (dead_q),
      .en_q     (en_q)
   );

   pwm3_updown #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .period_in (period_q),
      .cnt_q     (cnt_q),
      .per_act   (per_act),
      .load      (load),
      .apex      (apex)
   );

   generate
      for (genvar g = 0; g < NPH; g++) begin : g_leg
         pwm3_leg #(.CNT_W(CNT_W), .DT_W(DT_W)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_q),
            .allow   (allow),
            .load    (load),
            .cnt     (cnt_q),
            .per_act (per_act),
            .cmp_in  (cmp_in[g]),
            .dead    (dead_q),
            .hi      (gate_hi[g]),
            .lo      (gate_lo[g])
         );
      end
   endgenerate

   // two stages, matching compare register plus gate register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_p1  <= 1'b0;
         adc_trig <= 1'b0;
      end else begin
         trig_p1  <= apex;
         adc_trig <= en_q && trig_p1;
      end
   end

endmodule

// File: rtl/pwm3_bridge_chk.sv
module pwm3_bridge_chk #(
   parameter int CNT_W = 12,
   parameter int DT_W  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             pwm_off,
   input logic [DT_W-1:0]  dead_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] per_act,
   input logic [2:0]       gate_hi,
   input logic [2:0]       gate_lo,
   input logic             adc_trig
);

   // R2
   p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi & gate_lo) == 3'b000);

   generate
      for (genvar i = 0; i < 3; i++) begin : g_ph
         // R4
         p_gap_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dead_q != '0 && $rose(gate_hi[i])) |-> !$past(gate_lo[i]));
         p_gap_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dead_q != '0 && $rose(gate_lo[i])) |-> !$past(gate_hi[i]));
      end
   endgenerate

   // R8
   p_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_off |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

   // R9
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (gate_hi == 3'b000 && gate_lo == 3'b000 && !adc_trig));

   // R6
   p_trig_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |=> !adc_trig);

   // R7, R10
   p_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cnt_q != '0) |=> $stable(per_act));

   // R10
   p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= per_act);

endmodule

bind pwm3_bridge pwm3_bridge_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_q     (en_q),
   .pwm_off  (pwm_off),
   .dead_q   (dead_q),
   .cnt_q    (cnt_q),
   .per_act  (per_act),
   .gate_hi  (gate_hi),
   .gate_lo  (gate_lo),
   .adc_trig (adc_trig)
);

// File: tb/sim_pwm3_bridge.sv
module sim_pwm3_bridge;

   localparam int CLK_NS = 10;
   localparam int CW     = 8;
   localparam int DW     = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_addr = 2'd0;
   logic [CW-1:0] cfg_wdata = '0;
   logic [CW-1:0] cmp_a = '0, cmp_b = '0, cmp_c = '0;
   logic          pwm_off = 1'b0;
   logic [2:0]    gate_hi, gate_lo;
   logic          adc_trig;

   int checks = 0;
   int fails  = 0;
   int cur_d  = 2;
   bit mon_on = 1'b0;
   bit done   = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   pwm3_bridge #(.CNT_W(CW), .DT_W(DW), .PERIOD_RST(16), .DEAD_RST(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
      .pwm_off(pwm_off), .gate_hi(gate_hi), .gate_lo(gate_lo), .adc_trig(adc_trig)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = CW'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic int exp_hi(input int c, input int p, input int d);
      int w;
      if (c == 0) return 0;
      if (c >= p) return 2 * p;
      w = 2 * c - 1;
      return (w > d) ? w - d : 0;
   endfunction

   function automatic int exp_lo(input int c, input int p, input int d);
      int l;
      if (c == 0) return 2 * p;
      if (c >= p) return 0;
      l = 2 * p - 2 * c + 1;
      return (l > d) ? l - d : 0;
   endfunction

   task automatic wait_trig();
      do @(negedge clk); while (!adc_trig);
   endtask

   task automatic trig_gap(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!adc_trig && n < 1000);
   endtask

   // guard monitor: cycles with both gates of a phase low before a rise
   int  off_run [3];
   logic [2:0] hi_prev = '0, lo_prev = '0;
   always @(negedge clk) begin
      for (int i = 0; i < 3; i++) begin
         if (mon_on && ((gate_hi[i] && !hi_prev[i]) || (gate_lo[i] && !lo_prev[i])))
            chk(off_run[i] >= cur_d, "R4 guard before rise", off_run[i], cur_d);
         if (!gate_hi[i] && !gate_lo[i]) off_run[i]++;
         else off_run[i] = 0;
      end
      hi_prev = gate_hi;
      lo_prev = gate_lo;
   end

   task automatic measure_and_check(input int p, input int d, input int ca, input int cb, input int cc);
      int hi_n [3];
      int lo_n [3];
      int tr, ov;
      int cv [3];
      cv[0] = ca; cv[1] = cb; cv[2] = cc;
      tr = 0; ov = 0;
      for (int i = 0; i < 3; i++) begin hi_n[i] = 0; lo_n[i] = 0; end
      repeat (2 * p) begin
         @(negedge clk);
         for (int i = 0; i < 3; i++) begin
            hi_n[i] += int'(gate_hi[i]);
            lo_n[i] += int'(gate_lo[i]);
         end
         if (adc_trig) tr++;
         if ((gate_hi & gate_lo) != 3'b000) ov++;
      end
      for (int i = 0; i < 3; i++) begin
         // R3 for mid compares, R5 for 0 and >= P
         chk(hi_n[i] == exp_hi(cv[i], p, d), (cv[i] == 0 || cv[i] >= p) ? "R5 high on-time" : "R3 high on-time",
             hi_n[i], exp_hi(cv[i], p, d));
         chk(lo_n[i] == exp_lo(cv[i], p, d), (cv[i] == 0 || cv[i] >= p) ? "R5 low on-time" : "R3 low on-time",
             lo_n[i], exp_lo(cv[i], p, d));
      end
      chk(tr == 1, "R6 one trigger per window", tr, 1);
      chk(ov == 0, "R2 no overlap", ov, 0);
   endtask

   initial begin
      int n, p, d;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(gate_hi == 3'b000 && gate_lo == 3'b000 && !adc_trig, "R1 reset outputs",
          int'({gate_hi, gate_lo, adc_trig}), 0);
      // R9 idle with run bit cleared by reset
      seen = 1'b0;
      repeat (40) begin
         @(negedge clk);
         if (gate_hi != 0 || gate_lo != 0 || adc_trig) seen = 1'b1;
      end
      chk(!seen, "R9 idle after reset", int'(seen), 0);
      // R1 reset period 16: enable and time the trigger spacing
      wr(2, 1);
      wait_trig();
      trig_gap(n);
      chk(n == 32, "R1 reset period", n, 32);

      // R3 R5 sweep over period, guard and compare (register map per R11)
      foreach (p_list[pi]) begin
         foreach (d_list[di]) begin
            p = p_list[pi]; d = d_list[di];
            mon_on = 1'b0;
            wr(0, p); wr(1, d);
            cur_d = d;
            for (int c = 0; c <= p; c++) begin
               mon_on = 1'b0;
               @(negedge clk);
               cmp_a = CW'(c); cmp_b = CW'(p - c); cmp_c = CW'((c * 3) % (p + 2));
               repeat (8 * p) @(negedge clk);
               mon_on = 1'b1;
               measure_and_check(p, d, c, p - c, (c * 3) % (p + 2));
            end
         end
      end
      mon_on = 1'b0;

      // R6 trigger position relative to low-side rise: P=12 d=2 c=4
      wr(0, 12); wr(1, 2); cur_d = 2;
      @(negedge clk); cmp_a = 8'd4; cmp_b = 8'd6; cmp_c = 8'd0;
      repeat (100) @(negedge clk);
      do @(negedge clk); while (!(gate_lo[0] && !lo_prev_sample()));
      trig_gap(n);
      chk(n == 12 - 4 - 2, "R6 trigger offset", n, 6);

      // R7 compare shadow: change at trigger, fall still uses old value
      @(negedge clk); cmp_a = 8'd3;
      repeat (100) @(negedge clk);
      wait_trig();
      cmp_a = 8'd9;
      n = 0;
      do begin @(negedge clk); n++; end while (gate_lo[0] && n < 100);
      chk(n == 12 - 3 + 1, "R7 shadowed compare", n, 10);
      repeat (100) @(negedge clk);
      mon_on = 1'b1;
      measure_and_check(12, 2, 9, 6, 0);
      mon_on = 1'b0;

      // R8 kill path
      @(negedge clk); pwm_off = 1'b1;
      @(negedge clk);
      chk(gate_hi == 0 && gate_lo == 0, "R8 gates low after kill", int'({gate_hi, gate_lo}), 0);
      seen = 1'b0;
      repeat (30) begin @(negedge clk); if (gate_hi != 0 || gate_lo != 0) seen = 1'b1; end
      chk(!seen, "R8 gates held low", int'(seen), 0);
      wr(1, 5); cur_d = 5;
      pwm_off = 1'b0;
      seen = 1'b0;
      repeat (5) begin @(negedge clk); if (gate_hi != 0 || gate_lo != 0) seen = 1'b1; end
      chk(!seen, "R8 guard after release", int'(seen), 0);
      repeat (60) @(negedge clk);
      mon_on = 1'b1;
      measure_and_check(12, 5, 9, 6, 0);
      mon_on = 1'b0;

      // R10 period change at the next zero
      wait_trig();
      wr(0, 8);
      // interval measured from the trigger already seen
      n = 2;
      do begin @(negedge clk); n++; end while (!adc_trig && n < 1000);
      chk(n == 12 + 8, "R10 spanning interval", n, 20);
      trig_gap(n);
      chk(n == 16, "R10 new interval", n, 16);
      wr(0, 1);
      wait_trig();
      wait_trig();
      trig_gap(n);
      chk(n == 4, "R10 period floor", n, 4);

      // R9 run bit cleared
      wr(2, 0);
      @(negedge clk);
      seen = 1'b0;
      repeat (40) begin @(negedge clk); if (gate_hi != 0 || gate_lo != 0 || adc_trig) seen = 1'b1; end
      chk(!seen, "R9 idle when stopped", int'(seen), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   int p_list [2] = '{8, 12};
   int d_list [2] = '{1, 4};

   function automatic bit lo_prev_sample();
      return lo_prev_hold;
   endfunction

   logic lo_prev_hold = 1'b0;
   always @(posedge clk) lo_prev_hold <= gate_lo[0];

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule